// File: doc/BRIEF.md
# Sampled Monitoring Event Capture

This block sits beside a trigger pipeline. It takes a sparse, pseudo-random sample of bunch-crossings and sends each sampled one to a monitoring consumer as a complete event. Every valid crossing brings in a crossing identifier, a word of raw input data, a word of output segment data, a flag that at least one segment was found, and a flag that a found segment falls outside the angular cut. A programmable eligibility mode chooses which crossings may be sampled. A 16-bit pseudo-random sequence, compared against a programmed threshold, then thins the eligible ones.

When a crossing is taken, the block records it and the following valid crossings, up to a programmed window of 1 to 8 crossings. It then sends one packet on a valid/ready stream. The packet is a header word followed by one word per captured crossing, in arrival order. While an event is being captured or sent, the block takes no further samples. It counts each sample it declines because it is busy.

The controller has four states. `ST_IDLE` waits for a taken crossing. `ST_CAPTURE` collects the rest of the window. `ST_HEADER` offers the header. `ST_PAYLOAD` offers the captured words. The transitions are:
- take-short: `ST_IDLE` to `ST_HEADER`, when a one-crossing window is taken.
- take-long: `ST_IDLE` to `ST_CAPTURE`, when a longer window is taken.
- window-full: `ST_CAPTURE` to `ST_HEADER`, when the last crossing of the window is stored.
- header-accepted: `ST_HEADER` to `ST_PAYLOAD`, when the header is handed over.
- payload-step: `ST_PAYLOAD` back to itself, when a word other than the last is handed over.
- packet-done: `ST_PAYLOAD` to `ST_IDLE`, when the last word is handed over.

Top module: `mon_event_sampler`

## Requirements
- R1: After a synchronous active-high reset, the block is in `ST_IDLE` with `pkt_valid` low and `dropped_cnt` zero, and the pseudo-random register holds 16'hACE1.
- R2: The pseudo-random register advances once per cycle with `xing_valid` high. It shifts right, and when the bit shifted out is 1 it XORs the result with 16'hB400. A crossing is taken only if it is eligible and the register value before the advance is strictly below `cfg_thresh`, so a threshold of 0 takes nothing.
- R3: With `cfg_mode` = 0, every valid crossing is eligible.
- R4: With `cfg_mode` = 1, a crossing is eligible only when `seg_found` is high.
- R5: With `cfg_mode` = 2, a crossing is eligible only when both `seg_found` and `out_of_cut` are high. With `cfg_mode` = 3, no crossing is eligible.
- R6: `cfg_win_m1` holds the window length minus one (0 to 7). The event holds the taken crossing and the next `cfg_win_m1` valid crossings. Cycles with `xing_valid` low are skipped. Each crossing is stored as one word {`xing_seg`, `xing_in`}, with the segment data in the upper half.
- R7: The first word of each packet is a header. Bits [11:0] hold the crossing identifier of the taken crossing, bits [14:12] the window length minus one, bits [16:15] the mode. All higher bits are zero.
- R8: After the header come the captured words, oldest first. `pkt_last` is high only together with `pkt_valid`, and only on the final captured word.
- R9: A word is handed over only in a cycle with both `pkt_valid` and `pkt_ready` high. While `pkt_ready` is low, `pkt_valid`, `pkt_data` and `pkt_last` hold steady.
- R10: A crossing that would be taken while the block is in `ST_CAPTURE`, `ST_HEADER` or `ST_PAYLOAD` starts nothing. It raises `dropped_cnt` by one in the next cycle, and the count saturates at its maximum.
- R11: Mode and window length are latched when a crossing is taken. Changes to `cfg_mode` or `cfg_win_m1` during capture or readout do not alter that packet's length or header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xing_valid | input | 1 | A crossing is presented this cycle |
| xing_bcid | input | 12 | Crossing identifier |
| xing_in | input | 16 | Raw input data of the crossing |
| xing_seg | input | 16 | Output segment data of the crossing |
| seg_found | input | 1 | At least one segment found in the crossing |
| out_of_cut | input | 1 | A found segment lies outside the angular cut |
| cfg_mode | input | 2 | Eligibility mode |
| cfg_thresh | input | 16 | Sampling threshold |
| cfg_win_m1 | input | 3 | Window length minus one |
| pkt_valid | output | 1 | Packet word offered |
| pkt_ready | input | 1 | Consumer accepts the word |
| pkt_data | output | 32 | Packet word |
| pkt_last | output | 1 | Final word of the packet |
| dropped_cnt | output | 16 | Samples declined while busy |

## Verification
Every result is registered and appears one clock after the edge that causes it:
- The header is offered in the cycle after the last crossing of the window is stored.
- Each later packet word is offered in the cycle after the previous word is accepted.
- A declined sample shows in `dropped_cnt` in the cycle after its crossing.

The reference model therefore advances at each rising edge on the same inputs that the design samples. It compares its predicted outputs against the design at the falling edge that follows, so every expected value is taken in the cycle it is due. Stimulus changes only after that comparison.

// File: rtl/mon_sample_pkg.sv
package mon_sample_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_HEADER  = 2'd2,
        ST_PAYLOAD = 2'd3
    } cap_state_e;

    // Eligibility codes; the numeric values are part of the header
    typedef enum logic [1:0] {
        SEL_ANY     = 2'd0,
        SEL_SEGMENT = 2'd1,
        SEL_OUTSIDE = 2'd2,
        SEL_NONE    = 2'd3
    } sel_mode_e;

endpackage

// File: rtl/mon_lfsr.sv
module mon_lfsr #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'hB400,
    parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] shifted;

    // Galois form: shift right, fold taps in when a one falls out
    always_comb begin
        shifted = value >> 1;
        if (value[0]) begin
            shifted = shifted ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= SEED;
        end else if (step) begin
            value <= shifted;
        end
    end

endmodule

// File: rtl/mon_select.sv
module mon_select
    import mon_sample_pkg::*;
#(
    parameter int RND_W = 16
) (
    input  logic             xing_valid,
    input  logic             seg_found,
    input  logic             out_of_cut,
    input  logic [1:0]       mode,
    input  logic [RND_W-1:0] rnd,
    input  logic [RND_W-1:0] thresh,
    output logic             taken
);

    logic eligible;

    always_comb begin
        unique case (sel_mode_e'(mode))
            SEL_ANY:     eligible = 1'b1;
            SEL_SEGMENT: eligible = seg_found;
            SEL_OUTSIDE: eligible = seg_found && out_of_cut;
            SEL_NONE:    eligible = 1'b0;
        endcase
    end

    assign taken = xing_valid && eligible && (rnd < thresh);

endmodule

// File: rtl/mon_event_buf.sv
module mon_event_buf #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 32,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_addr] <= wr_data;
        end
    end

    assign rd_data = slots[rd_addr];

endmodule

// File: rtl/mon_event_sampler.sv
module mon_event_sampler
    import mon_sample_pkg::*;
#(
    parameter int BCID_W  = 12,
    parameter int IN_W    = 16,
    parameter int SEG_W   = 16,
    parameter int MAX_WIN = 8,
    parameter int RND_W   = 16,
    parameter int CNT_W   = 16,
    localparam int WIN_W  = $clog2(MAX_WIN),
    localparam int PKT_W  = IN_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xing_valid,
    input  logic [BCID_W-1:0] xing_bcid,
    input  logic [IN_W-1:0]   xing_in,
    input  logic [SEG_W-1:0]  xing_seg,
    input  logic              seg_found,
    input  logic              out_of_cut,
    input  logic [1:0]        cfg_mode,
    input  logic [RND_W-1:0]  cfg_thresh,
    input  logic [WIN_W-1:0]  cfg_win_m1,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [PKT_W-1:0]  pkt_data,
    output logic              pkt_last,
    output logic [CNT_W-1:0]  dropped_cnt
);

    localparam int HDR_USED = BCID_W + WIN_W + 2;
    localparam int HDR_PAD  = PKT_W - HDR_USED;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cap_state_e        state_q, state_d;
    logic [RND_W-1:0]  rnd;
    logic              taken;
    logic [WIN_W-1:0]  win_q;
    logic [1:0]        mode_q;
    logic [BCID_W-1:0] bcid_q;
    logic [WIN_W-1:0]  wr_idx, rd_idx;
    logic              wr_en;
    logic [WIN_W-1:0]  wr_addr;
    logic [PKT_W-1:0]  rd_word;
    logic              start;
    logic              hs;

    mon_lfsr #(.WIDTH(RND_W)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .step  (xing_valid),
        .value (rnd)
    );

    mon_select #(.RND_W(RND_W)) u_select (
        .xing_valid (xing_valid),
        .seg_found  (seg_found),
        .out_of_cut (out_of_cut),
        .mode       (cfg_mode),
        .rnd        (rnd),
        .thresh     (cfg_thresh),
        .taken      (taken)
    );

    mon_event_buf #(.DEPTH(MAX_WIN), .WORD_W(PKT_W)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data ({xing_seg, xing_in}),
        .rd_addr (rd_idx),
        .rd_data (rd_word)
    );

    assign start   = (state_q == ST_IDLE) && taken;
    assign hs      = pkt_valid && pkt_ready;
    assign wr_en   = start || ((state_q == ST_CAPTURE) && xing_valid);
    assign wr_addr = (state_q == ST_IDLE) ? '0 : wr_idx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (taken) begin
                    state_d = (cfg_win_m1 == '0) ? ST_HEADER : ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                if (xing_valid && (wr_idx == win_q)) begin
                    state_d = ST_HEADER;
                end
            end
            ST_HEADER: begin
                if (pkt_ready) begin
                    state_d = ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                if (pkt_ready && (rd_idx == win_q)) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Event context and indices
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            mode_q <= '0;
            bcid_q <= '0;
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (start) begin
                win_q  <= cfg_win_m1;
                mode_q <= cfg_mode;
                bcid_q <= xing_bcid;
                wr_idx <= WIN_W'(1);
            end else if ((state_q == ST_CAPTURE) && xing_valid) begin
                wr_idx <= wr_idx + WIN_W'(1);
            end
            if (state_q == ST_HEADER) begin
                rd_idx <= '0;
            end else if ((state_q == ST_PAYLOAD) && hs) begin
                rd_idx <= rd_idx + WIN_W'(1);
            end
        end
    end

    // Samples declined while busy
    always_ff @(posedge clk) begin
        if (rst) begin
            dropped_cnt <= '0;
        end else if (taken && (state_q != ST_IDLE) && (dropped_cnt != CNT_MAX)) begin
            dropped_cnt <= dropped_cnt + CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        pkt_valid = 1'b0;
        pkt_data  = '0;
        pkt_last  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CAPTURE: begin
                pkt_valid = 1'b0;
            end
            ST_HEADER: begin
                pkt_valid = 1'b1;
                pkt_data  = {{HDR_PAD{1'b0}}, mode_q, win_q, bcid_q};
            end
            ST_PAYLOAD: begin
                pkt_valid = 1'b1;
                pkt_data  = rd_word;
                pkt_last  = (rd_idx == win_q);
            end
        endcase
    end

endmodule

// File: rtl/mon_sampler_chk.sv
module mon_sampler_chk
    import mon_sample_pkg::*;
#(
    parameter int PKT_W = 32,
    parameter int WIN_W = 3,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input cap_state_e       state_q,
    input logic             taken,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [PKT_W-1:0] pkt_data,
    input logic             pkt_last,
    input logic [CNT_W-1:0] dropped_cnt,
    input logic             wr_en,
    input logic [WIN_W-1:0] wr_addr,
    input logic [WIN_W-1:0] win_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));

    // R8
    last_in_packet_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_last |-> pkt_valid);

    // R10
    drop_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dropped_cnt >= $past(dropped_cnt)));

    // R10
    drop_counts_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (taken && (state_q != ST_IDLE) && (dropped_cnt != CNT_MAX))
        |=> (dropped_cnt == $past(dropped_cnt) + CNT_W'(1)));

    // R6
    write_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (state_q == ST_CAPTURE)) |-> (wr_addr <= win_q));

endmodule

bind mon_event_sampler mon_sampler_chk #(
    .PKT_W (PKT_W),
    .WIN_W (WIN_W),
    .CNT_W (CNT_W)
) u_sampler_chk (
    .clk         (clk),
    .rst         (rst),
    .state_q     (state_q),
    .taken       (taken),
    .pkt_valid   (pkt_valid),
    .pkt_ready   (pkt_ready),
    .pkt_data    (pkt_data),
    .pkt_last    (pkt_last),
    .dropped_cnt (dropped_cnt),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .win_q       (win_q)
);

// File: tb/test_mon_event_sampler.sv
`timescale 1ns/1ps
module test_mon_event_sampler;

    localparam int BCID_W = 12;
    localparam int IN_W   = 16;
    localparam int SEG_W  = 16;
    localparam int WIN_W  = 3;
    localparam int CNT_W  = 16;
    localparam int PKT_W  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              xing_valid = 0;
    logic [BCID_W-1:0] xing_bcid  = '0;
    logic [IN_W-1:0]   xing_in    = '0;
    logic [SEG_W-1:0]  xing_seg   = '0;
    logic              seg_found  = 0;
    logic              out_of_cut = 0;
    logic [1:0]        cfg_mode   = '0;
    logic [15:0]       cfg_thresh = '0;
    logic [WIN_W-1:0]  cfg_win_m1 = '0;
    logic              pkt_ready  = 0;
    logic              pkt_valid;
    logic [PKT_W-1:0]  pkt_data;
    logic              pkt_last;
    logic [CNT_W-1:0]  dropped_cnt;

    mon_event_sampler i_mon_event_sampler (
        .clk(clk), .rst(rst), .xing_valid(xing_valid), .xing_bcid(xing_bcid),
        .xing_in(xing_in), .xing_seg(xing_seg), .seg_found(seg_found),
        .out_of_cut(out_of_cut), .cfg_mode(cfg_mode), .cfg_thresh(cfg_thresh),
        .cfg_win_m1(cfg_win_m1), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_data(pkt_data), .pkt_last(pkt_last), .dropped_cnt(dropped_cnt)
    );

    int  vectors = 0;
    int  errors  = 0;
    bit  done    = 0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    function automatic bit eligible(input logic [1:0] m, input logic sf, input logic oc);
        case (m)
            2'd0: return 1'b1;
            2'd1: return sf;
            2'd2: return sf && oc;
            default: return 1'b0;
        endcase
    endfunction

    // Behavioural reference: 0 idle, 1 capture, 2 header, 3 payload
    int               m_st = 0;
    logic [15:0]      m_lf = 16'hACE1;
    logic [BCID_W-1:0] m_bc;
    int               m_win = 1;
    logic [1:0]       m_mode;
    logic [PKT_W-1:0] m_q[$];
    int               m_idx = 0;
    int               m_drop = 0;
    int               m_pkts = 0;
    int               d_pkts = 0;

    always @(posedge clk) begin
        bit tk;
        if (rst) begin
            m_st = 0; m_lf = 16'hACE1; m_drop = 0; m_idx = 0; m_q.delete();
        end else begin
            tk = xing_valid && eligible(cfg_mode, seg_found, out_of_cut) && (m_lf < cfg_thresh);
            if (tk && m_st != 0 && m_drop < 65535) m_drop++;
            case (m_st)
                0: if (tk) begin
                    m_bc = xing_bcid; m_mode = cfg_mode; m_win = int'(cfg_win_m1) + 1;
                    m_q.delete(); m_q.push_back({xing_seg, xing_in});
                    m_st = (m_win == 1) ? 2 : 1;
                end
                1: if (xing_valid) begin
                    m_q.push_back({xing_seg, xing_in});
                    if (m_q.size() == m_win) m_st = 2;
                end
                2: if (pkt_ready) begin m_st = 3; m_idx = 0; end
                default: if (pkt_ready) begin
                    if (m_idx == m_win - 1) begin m_st = 0; m_pkts++; end
                    else m_idx++;
                end
            endcase
            if (xing_valid) m_lf = lfsr_next(m_lf);
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_cycle(input string phase);
        logic [PKT_W-1:0] ed;
        bit ev, el;
        ev = (m_st >= 2);
        el = (m_st == 3) && (m_idx == m_win - 1);
        ed = (m_st == 2) ? {15'd0, m_mode, 3'(m_win - 1), m_bc} : ((m_st == 3) ? m_q[m_idx] : '0);
        check({"R8 pkt_valid / ", phase}, 64'(pkt_valid), 64'(ev));
        if (ev) begin
            check((m_st == 2) ? {"R7 header / ", phase} : {"R6 payload word / ", phase},
                  64'(pkt_data), 64'(ed));
            check({"R8 pkt_last / ", phase}, 64'(pkt_last), 64'(el));
        end
        check({"R10 dropped_cnt / ", phase}, 64'(dropped_cnt), 64'(m_drop));
        if (pkt_valid && pkt_ready && pkt_last) d_pkts++;
    endtask

    // One phase; R9 is covered through random pkt_ready stalls
    task automatic run_phase(input string phase, input int mode, input int thr,
                             input int winm1, input int rdy_pct, input int n, input bit jitter);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_cycle(phase);
            xing_valid = (rnd() % 4) != 0;
            if (xing_valid) xing_bcid = xing_bcid + 1'b1;
            xing_in    = 16'(rnd());
            xing_seg   = 16'(rnd());
            seg_found  = (rnd() % 3) == 0;
            out_of_cut = (rnd() % 2) == 0;
            cfg_thresh = 16'(thr);
            cfg_mode   = jitter ? 2'(rnd() % 2) : 2'(mode);
            cfg_win_m1 = jitter ? 3'(rnd()) : 3'(winm1);
            pkt_ready  = (rnd() % 100) < rdy_pct;
        end
    endtask

    task automatic phase_count(input string tag, input int p0, input int m0, input bit want_some);
        check({tag, " packet count vs model"}, 64'(d_pkts - p0), 64'(m_pkts - m0));
        if (want_some) check({tag, " packets produced"}, 64'((d_pkts - p0) > 0), 64'd1);
        else           check({tag, " no packets"}, 64'(d_pkts - p0), 64'd0);
    endtask

    initial begin
        int p0, m0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 pkt_valid after reset", 64'(pkt_valid), 64'd0);
        check("R1 dropped_cnt after reset", 64'(dropped_cnt), 64'd0);

        p0 = d_pkts; m0 = m_pkts;
        run_phase("R2 threshold zero", 0, 0, 3, 100, 300, 0);
        phase_count("R2", p0, m0, 0);

        p0 = d_pkts; m0 = m_pkts;
        run_phase("R3 any crossing", 0, 16'h2000, 2, 100, 800, 0);
        phase_count("R3", p0, m0, 1);

        p0 = d_pkts; m0 = m_pkts;
        run_phase("R4 segment found", 1, 16'hFFFF, 0, 60, 800, 0);
        phase_count("R4", p0, m0, 1);

        p0 = d_pkts; m0 = m_pkts;
        run_phase("R5 outside cut", 2, 16'hC000, 7, 50, 1200, 0);
        phase_count("R5 mode 2", p0, m0, 1);

        // R11: configuration changes every cycle during capture and readout
        p0 = d_pkts; m0 = m_pkts;
        run_phase("R11 config jitter", 0, 16'h8000, 0, 70, 1000, 1);
        phase_count("R11", p0, m0, 1);

        run_phase("drain", 0, 0, 0, 100, 60, 0);
        p0 = d_pkts; m0 = m_pkts;
        run_phase("R5 mode 3", 3, 16'hFFFF, 4, 100, 400, 0);
        phase_count("R5 mode 3", p0, m0, 0);

        // R10: busy periods above must have declined some samples
        check("R10 some samples declined", 64'(dropped_cnt > 0), 64'd1);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule